// File: doc/BRIEF.md
# Nibble Data Store with Split Pointer

This block is the data-memory side of a small 4-bit processor core. It keeps an array of 4-bit digits arranged as rows, each row holding sixteen digits, and a pointer register made of two fields. The upper field picks a row and the lower field picks a digit within that row. The digit the pointer names is always visible on a read bus. The core's decoder can copy that digit into the accumulator, store the accumulator into it, or swap the two in a single clock.

The pointer can be loaded in three ways. The row field and the digit field each take the low bits of the accumulator, and either field can be loaded on its own. An immediate operand can also replace the whole pointer at once, for direct addressing. On a separate command, the digit field is copied into a registered 4-bit output port.

The default build has eight rows and a 7-bit pointer. Setting `ROWS` to 4 gives the four-row build with a 6-bit pointer. Instruction decoding, arithmetic, and the other data sources that feed the accumulator are outside the block. They appear only as strobes and a data bus.

Top module: `digit_store`

## Requirements
- R1: The array holds `ROWS` x 16 digits of 4 bits. The pointer is `$clog2(ROWS)+4` bits wide, with the row in the upper bits and the digit index in the low 4 bits. `mem_q` shows the addressed digit combinationally.
- R2: With `st_mem` high, the digit addressed before the edge takes the accumulator value, and the accumulator keeps its value.
- R3: With `ld_mem` high, the accumulator takes the addressed digit at the edge.
- R4: With `swap` high, in one edge the addressed digit takes the old accumulator value and the accumulator takes the old digit value.
- R5: With `acc_wr` high, the accumulator takes `acc_din`.
- R6: With `row_from_acc` high and no immediate load, the row field takes the low `$clog2(ROWS)` accumulator bits. The digit field is unchanged unless it is loaded in the same cycle.
- R7: With `dig_from_acc` high and no immediate load, the digit field takes the accumulator value. The row field is unchanged unless it is loaded in the same cycle.
- R8: With `ptr_imm_ld` high, the whole pointer takes `ptr_imm`, and any field loads in the same cycle are ignored.
- R9: With `port_ld` high, `port_q` takes the digit field as it stood before that edge. Otherwise `port_q` holds.
- R10: Reset (active-low, asynchronous) clears the pointer, the port and the accumulator. The digit array keeps its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_wr | input | 1 | Load accumulator from `acc_din` |
| acc_din | input | 4 | External accumulator source |
| ld_mem | input | 1 | Copy addressed digit into accumulator |
| st_mem | input | 1 | Store accumulator into addressed digit |
| swap | input | 1 | Exchange addressed digit and accumulator |
| row_from_acc | input | 1 | Load row field from accumulator |
| dig_from_acc | input | 1 | Load digit field from accumulator |
| ptr_imm_ld | input | 1 | Load the whole pointer from `ptr_imm` |
| ptr_imm | input | $clog2(ROWS)+4 | Immediate pointer value |
| port_ld | input | 1 | Copy digit field to the output port |
| acc_q | output | 4 | Accumulator |
| mem_q | output | 4 | Addressed digit |
| ptr_q | output | $clog2(ROWS)+4 | Pointer {row, digit} |
| port_q | output | 4 | Registered digit output port |

## Verification
The assertions assume that the decoder raises at most one of the four accumulator commands (`acc_wr`, `ld_mem`, `st_mem`, `swap`) in any cycle. One assertion checks this at the top. The bench draws one accumulator command per cycle and combines it freely with pointer loads and port copies, so mixed cycles are exercised without breaking the assumption. Reads and swaps start only after every digit has been written once, because the array's power-up contents are undefined.

// File: rtl/digit_store_pkg.sv
package digit_store_pkg;
    localparam int DIGIT_W = 4;
    localparam int DIGITS_PER_ROW = 16;
    localparam int DIGIT_IDX_W = $clog2(DIGITS_PER_ROW);

    typedef logic [DIGIT_W-1:0] digit_t;

    typedef enum logic [1:0] {
        ACC_KEEP = 2'd0,
        ACC_MEM  = 2'd1,
        ACC_BUS  = 2'd2
    } acc_src_e;
endpackage

// File: rtl/ds_pointer.sv
module ds_pointer
    import digit_store_pkg::*;
#(
    parameter int RW = 3,
    localparam int PW = RW + DIGIT_IDX_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   imm_ld,
    input  logic [PW-1:0]          imm_val,
    input  logic                   row_ld,
    input  logic                   dig_ld,
    input  digit_t                 acc_val,
    input  logic                   port_ld,
    output logic [RW-1:0]          row_q,
    output logic [DIGIT_IDX_W-1:0] dig_q,
    output digit_t                 port_q
);
    typedef struct packed {
        logic [RW-1:0]          row;
        logic [DIGIT_IDX_W-1:0] dig;
        digit_t                 port;
    } ptr_state_t;

    ptr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (imm_ld) begin
            {st_d.row, st_d.dig} = imm_val;
        end else begin
            if (row_ld) st_d.row = acc_val[RW-1:0];
            if (dig_ld) st_d.dig = acc_val[DIGIT_IDX_W-1:0];
        end
        if (port_ld) st_d.port = digit_t'(st_q.dig);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign row_q  = st_q.row;
    assign dig_q  = st_q.dig;
    assign port_q = st_q.port;

    // R8
    imm_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        imm_ld |=> {row_q, dig_q} == $past(imm_val));
    // R6
    row_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!imm_ld && row_ld) |=> row_q == $past(acc_val[RW-1:0]));
    // R7
    dig_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!imm_ld && dig_ld) |=> dig_q == $past(acc_val[DIGIT_IDX_W-1:0]));
    // R6
    dig_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!imm_ld && !dig_ld) |=> $stable(dig_q));
    // R9
    port_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        port_ld |=> port_q == digit_t'($past(dig_q)));
    // R9
    port_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !port_ld |=> $stable(port_q));
endmodule

// File: rtl/ds_array.sv
module ds_array
    import digit_store_pkg::*;
#(
    parameter int ROWS = 8,
    localparam int RW = $clog2(ROWS)
) (
    input  logic                   clk,
    input  logic                   we,
    input  logic [RW-1:0]          row_sel,
    input  logic [DIGIT_IDX_W-1:0] dig_sel,
    input  digit_t                 wdata,
    output digit_t                 rdata
);
    digit_t row_rd [ROWS];

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        digit_t cells [DIGITS_PER_ROW];
        logic   row_we;

        assign row_we = we && (row_sel == RW'(r));

        // no reset: contents survive rst_n
        always_ff @(posedge clk) begin
            if (row_we) cells[dig_sel] <= wdata;
        end

        assign row_rd[r] = cells[dig_sel];
    end

    assign rdata = row_rd[row_sel];
endmodule

// File: rtl/ds_accum.sv
module ds_accum
    import digit_store_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   take_mem,
    input  digit_t mem_val,
    input  logic   take_bus,
    input  digit_t bus_val,
    output digit_t acc_q
);
    acc_src_e src;
    digit_t   acc_d, acc_r;

    always_comb begin
        if (take_mem)      src = ACC_MEM;
        else if (take_bus) src = ACC_BUS;
        else               src = ACC_KEEP;
        case (src)
            ACC_MEM: acc_d = mem_val;
            ACC_BUS: acc_d = bus_val;
            default: acc_d = acc_r;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_r <= '0;
        else        acc_r <= acc_d;
    end

    assign acc_q = acc_r;

    // R3
    acc_from_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_mem |=> acc_q == $past(mem_val));
    // R5
    acc_from_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_bus && !take_mem) |=> acc_q == $past(bus_val));
endmodule

// File: rtl/digit_store.sv
module digit_store
    import digit_store_pkg::*;
#(
    parameter int ROWS = 8,
    localparam int RW = $clog2(ROWS),
    localparam int PW = RW + DIGIT_IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_wr,
    input  logic [3:0]    acc_din,
    input  logic          ld_mem,
    input  logic          st_mem,
    input  logic          swap,
    input  logic          row_from_acc,
    input  logic          dig_from_acc,
    input  logic          ptr_imm_ld,
    input  logic [PW-1:0] ptr_imm,
    input  logic          port_ld,
    output logic [3:0]    acc_q,
    output logic [3:0]    mem_q,
    output logic [PW-1:0] ptr_q,
    output logic [3:0]    port_q
);
    logic [RW-1:0]          row_cur;
    logic [DIGIT_IDX_W-1:0] dig_cur;
    digit_t                 rd_digit, acc_cur;
    logic                   arr_we, acc_take_mem;

    assign arr_we       = st_mem || swap;
    assign acc_take_mem = ld_mem || swap;

    ds_pointer #(.RW(RW)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .imm_ld  (ptr_imm_ld),
        .imm_val (ptr_imm),
        .row_ld  (row_from_acc),
        .dig_ld  (dig_from_acc),
        .acc_val (acc_cur),
        .port_ld (port_ld),
        .row_q   (row_cur),
        .dig_q   (dig_cur),
        .port_q  (port_q)
    );

    ds_array #(.ROWS(ROWS)) u_arr (
        .clk     (clk),
        .we      (arr_we),
        .row_sel (row_cur),
        .dig_sel (dig_cur),
        .wdata   (acc_cur),
        .rdata   (rd_digit)
    );

    ds_accum u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .take_mem (acc_take_mem),
        .mem_val  (rd_digit),
        .take_bus (acc_wr),
        .bus_val  (acc_din),
        .acc_q    (acc_cur)
    );

    assign acc_q = acc_cur;
    assign mem_q = rd_digit;
    assign ptr_q = {row_cur, dig_cur};

    logic ptr_moves;
    assign ptr_moves = ptr_imm_ld || row_from_acc || dig_from_acc;

    // R4 (input assumption: one accumulator command per cycle)
    one_acc_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({acc_wr, ld_mem, st_mem, swap}));
    // R4
    swap_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (swap && !ptr_moves) |=> mem_q == $past(acc_q));
    // R4
    swap_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swap |=> acc_q == $past(mem_q));
    // R2
    store_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_mem && !ptr_moves) |=> mem_q == $past(acc_q));
    // R2
    store_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_mem |=> $stable(acc_q));
endmodule

// File: tb/digit_store_tb.sv
module digit_store_tb_top;
    localparam int ROWS = 8;
    localparam int RW = $clog2(ROWS);
    localparam int PW = RW + 4;
    localparam int NCELL = ROWS * 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_wr = 0, ld_mem = 0, st_mem = 0, swap = 0;
    logic row_from_acc = 0, dig_from_acc = 0, ptr_imm_ld = 0, port_ld = 0;
    logic [3:0] acc_din = '0;
    logic [PW-1:0] ptr_imm = '0;
    logic [3:0] acc_q, mem_q, port_q;
    logic [PW-1:0] ptr_q;

    always #2.5 clk = ~clk;

    digit_store #(.ROWS(ROWS)) dut_i (
        .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .acc_din(acc_din),
        .ld_mem(ld_mem), .st_mem(st_mem), .swap(swap),
        .row_from_acc(row_from_acc), .dig_from_acc(dig_from_acc),
        .ptr_imm_ld(ptr_imm_ld), .ptr_imm(ptr_imm), .port_ld(port_ld),
        .acc_q(acc_q), .mem_q(mem_q), .ptr_q(ptr_q), .port_q(port_q)
    );

    // reference model
    int m_mem [NCELL];
    bit m_known [NCELL];
    int m_row, m_dig, m_acc, m_port;
    int n_cmp = 0, n_bad = 0;
    string cur_tag;

    task automatic chk(string tag, string what, int got, int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, got, exp);
        end
    endtask

    task automatic compare_all();
        int idx = m_row * 16 + m_dig;
        chk(cur_tag, "acc_q", int'(acc_q), m_acc);
        chk(cur_tag, "ptr_q", int'(ptr_q), m_row * 16 + m_dig);
        chk(port_ld ? "R9" : cur_tag, "port_q", int'(port_q), m_port);
        if (m_known[idx]) chk("R1", "mem_q", int'(mem_q), m_mem[idx]);
    endtask

    // model update from the inputs driven this cycle, then compare next cycle
    task automatic tick();
        int idx = m_row * 16 + m_dig;
        int old_acc = m_acc;
        int old_dig = m_dig;
        if (swap || ld_mem) m_acc = m_mem[idx];
        else if (acc_wr) m_acc = int'(acc_din);
        if (swap || st_mem) begin
            m_mem[idx] = old_acc;
            m_known[idx] = 1'b1;
        end
        if (ptr_imm_ld) begin
            m_row = int'(ptr_imm) / 16;
            m_dig = int'(ptr_imm) % 16;
        end else begin
            if (row_from_acc) m_row = old_acc % ROWS;
            if (dig_from_acc) m_dig = old_acc;
        end
        if (port_ld) m_port = old_dig;
        @(negedge clk);
        compare_all();
    endtask

    task automatic clear_in();
        acc_wr = 0; ld_mem = 0; st_mem = 0; swap = 0;
        row_from_acc = 0; dig_from_acc = 0; ptr_imm_ld = 0; port_ld = 0;
    endtask

    task automatic random_cycle();
        int k = int'($urandom % 5);
        clear_in();
        case (k)
            0: begin acc_wr = 1; acc_din = 4'($urandom); cur_tag = "R5"; end
            1: begin ld_mem = 1; cur_tag = "R3"; end
            2: begin st_mem = 1; cur_tag = "R2"; end
            3: begin swap = 1; cur_tag = "R4"; end
            default: cur_tag = "R1";
        endcase
        k = int'($urandom % 6);
        if (k == 0) begin row_from_acc = 1; cur_tag = "R6"; end
        if (k == 1) begin dig_from_acc = 1; cur_tag = "R7"; end
        if (k == 2) begin row_from_acc = 1; dig_from_acc = 1; cur_tag = "R6"; end
        if (k == 3) begin
            ptr_imm_ld = 1; ptr_imm = PW'($urandom);
            row_from_acc = 1'($urandom); dig_from_acc = 1'($urandom);
            cur_tag = "R8";
        end
        port_ld = ($urandom % 3) == 0;
        tick();
    endtask

    initial begin
        for (int i = 0; i < NCELL; i++) begin m_mem[i] = 0; m_known[i] = 1'b0; end
        m_row = 0; m_dig = 0; m_acc = 0; m_port = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cur_tag = "R10";
        compare_all();

        // fill every digit: pointer by immediate, then store
        for (int a = 0; a < NCELL; a++) begin
            clear_in();
            ptr_imm_ld = 1; ptr_imm = PW'(a);
            acc_wr = 1; acc_din = 4'((a * 7 + 3) % 16);
            cur_tag = "R8";
            tick();
            clear_in();
            st_mem = 1; cur_tag = "R2";
            tick();
        end

        // directed swap with distinct values
        clear_in(); ptr_imm_ld = 1; ptr_imm = PW'(5); acc_wr = 1; acc_din = 4'd9;
        cur_tag = "R8"; tick();
        clear_in(); swap = 1; cur_tag = "R4"; tick();
        clear_in(); swap = 1; cur_tag = "R4"; tick();

        for (int n = 0; n < 2000; n++) random_cycle();

        // reset keeps array contents
        @(negedge clk);
        clear_in();
        rst_n = 1'b0;
        m_row = 0; m_dig = 0; m_acc = 0; m_port = 0;
        @(negedge clk);
        cur_tag = "R10";
        compare_all();
        rst_n = 1'b1;
        for (int a = 0; a < NCELL; a += 9) begin
            clear_in(); ptr_imm_ld = 1; ptr_imm = PW'(a); cur_tag = "R10"; tick();
        end

        for (int n = 0; n < 500; n++) random_cycle();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule